// File: doc/BRIEF.md
# Operand Effective Address Resolver

This block sits between instruction decode and execute. It takes the operand field of an instruction and a two-bit addressing-mode code, and produces the data value that the execute stage will use, together with the effective address that value came from. Depending on the mode, it makes zero, one or two reads through a synchronous memory read port. A small sequencer steps through those reads and then pulses a done strobe.

The block holds an index register, loaded through its own port, for the offset mode. A resolution starts when a start strobe arrives while the block is idle. The mode, the operand and the index value in effect at that moment are captured. Memory latency is not fixed: each read request stays asserted, with a steady address, until the memory returns data-valid.

Top module: `opnd_resolver`

## Requirements
- R1: After reset, done_o, mem_req_o and busy_o are low.
- R2: Mode code 2'b00 (immediate) makes no memory read. done_o rises one cycle after the accepted start, with value_o equal to the operand zero-extended to DATA_W and eaddr_o equal to the operand.
- R3: Mode code 2'b01 (direct) makes exactly one read, at the operand address. value_o is the returned word and eaddr_o is the operand.
- R4: Mode code 2'b10 (indirect) makes exactly two reads. The first is at the operand address. The second is at the low ADDR_W bits of the word the first read returns. value_o is the second word, and eaddr_o is that pointer.
- R5: Mode code 2'b11 (indexed) makes exactly one read, at (operand + index register) modulo ADDR_DEPTH. That address appears on eaddr_o. With the default depth of 256, operand 250 plus index 10 gives address 4.
- R6: While a read is pending, mem_req_o stays high and mem_addr_o stays unchanged until mem_valid_i is seen. The correct result is produced for any response latency.
- R7: done_o is high for exactly one cycle per accepted start. busy_o is low in the cycle after done_o.
- R8: busy_o is high from the cycle after an accepted start through the done cycle. A start_i that arrives while busy_o is high has no effect on the reads made or on the result.
- R9: An index load takes effect at the next clock edge, so a start in the following cycle uses the new value. A load made while a resolution is in progress does not change that resolution's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a resolution (taken only when idle) |
| mode_i | input | 2 | Addressing-mode code |
| operand_i | input | ADDR_W | Operand field of the instruction |
| idx_load_i | input | 1 | Load the index register |
| idx_value_i | input | ADDR_W | New index register value |
| mem_req_o | output | 1 | Read request, held until data-valid |
| mem_addr_o | output | ADDR_W | Read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | DATA_W | Read data |
| done_o | output | 1 | One-cycle result strobe |
| value_o | output | DATA_W | Resolved data value |
| eaddr_o | output | ADDR_W | Effective address |
| busy_o | output | 1 | Resolution in progress |

## Verification
The assertions take some things about the inputs for granted. mem_valid_i is raised only while mem_req_o is high, and only for one cycle per request. Operands and the index register are below ADDR_DEPTH, and the mode code is never unknown at a start. The bench's memory model answers only an outstanding request, with a single-cycle valid after a chosen latency. It drives starts only at or after the negative edge. All of its operands and index values stay inside the default 256-word space.

// File: rtl/opres_pkg.sv
package opres_pkg;
   typedef enum logic [1:0] {
      AM_IMM = 2'b00,
      AM_DIR = 2'b01,
      AM_IND = 2'b10,
      AM_IDX = 2'b11
   } amode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RD1  = 2'b01,
      ST_RD2  = 2'b10,
      ST_DONE = 2'b11
   } rstate_e;
endpackage

// File: rtl/opres_index_reg.sv
module opres_index_reg #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] value_i,
   output logic [ADDR_W-1:0] index_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      index_o <= '0;
      else if (load_i) index_o <= value_i;
   end
endmodule

// File: rtl/opres_addr_calc.sv
module opres_addr_calc #(
   parameter int ADDR_W     = 8,
   parameter int ADDR_DEPTH = 256
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] offset_i,
   output logic [ADDR_W-1:0] sum_o
);
   localparam int  SUM_W   = ADDR_W + 1;
   localparam bit  POW2    = (ADDR_DEPTH == (1 << ADDR_W));

   logic [SUM_W-1:0] raw;
   assign raw = SUM_W'(base_i) + SUM_W'(offset_i);

   generate
      if (POW2) begin : g_wrap_pow2
         assign sum_o = raw[ADDR_W-1:0];
      end else begin : g_wrap_mod
         logic [SUM_W-1:0] lim;
         assign lim   = SUM_W'(ADDR_DEPTH);
         assign sum_o = (raw >= lim) ? ADDR_W'(raw - lim) : raw[ADDR_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/opres_seq.sv
module opres_seq
   import opres_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic [ADDR_W-1:0] operand_i,
   input  logic [ADDR_W-1:0] idx_addr_i,
   input  logic              mem_valid_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              done_o,
   output logic [DATA_W-1:0] value_o,
   output logic              busy_o
);
   rstate_e           st_q;
   amode_e            mode_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] value_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         mode_q  <= AM_IMM;
         addr_q  <= '0;
         value_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               mode_q <= amode_e'(mode_i);
               unique case (amode_e'(mode_i))
                  AM_IMM: begin
                     addr_q  <= operand_i;
                     value_q <= DATA_W'(operand_i);
                     st_q    <= ST_DONE;
                  end
                  AM_IDX: begin
                     addr_q <= idx_addr_i;
                     st_q   <= ST_RD1;
                  end
                  default: begin
                     addr_q <= operand_i;
                     st_q   <= ST_RD1;
                  end
               endcase
            end
            ST_RD1: if (mem_valid_i) begin
               if (mode_q == AM_IND) begin
                  addr_q <= mem_data_i[ADDR_W-1:0];
                  st_q   <= ST_RD2;
               end else begin
                  value_q <= mem_data_i;
                  st_q    <= ST_DONE;
               end
            end
            ST_RD2: if (mem_valid_i) begin
               value_q <= mem_data_i;
               st_q    <= ST_DONE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_o = (st_q == ST_RD1) || (st_q == ST_RD2);
   assign done_o    = (st_q == ST_DONE);
   assign busy_o    = (st_q != ST_IDLE);
   assign addr_o    = addr_q;
   assign value_o   = value_q;
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 16,
   parameter int ADDR_DEPTH = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic [ADDR_W-1:0] operand_i,
   input  logic              idx_load_i,
   input  logic [ADDR_W-1:0] idx_value_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_valid_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic              done_o,
   output logic [DATA_W-1:0] value_o,
   output logic [ADDR_W-1:0] eaddr_o,
   output logic              busy_o
);
   generate
      if (DATA_W < ADDR_W) begin : g_chk_width
         $error("opnd_resolver: DATA_W must hold a full address");
      end
      if (ADDR_DEPTH > (1 << ADDR_W) || ADDR_DEPTH < 2) begin : g_chk_depth
         $error("opnd_resolver: ADDR_DEPTH out of range for ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] index_q;
   logic [ADDR_W-1:0] idx_sum;
   logic [ADDR_W-1:0] addr_w;

   opres_index_reg #(.ADDR_W(ADDR_W)) u_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (idx_load_i),
      .value_i (idx_value_i),
      .index_o (index_q)
   );

   opres_addr_calc #(.ADDR_W(ADDR_W), .ADDR_DEPTH(ADDR_DEPTH)) u_calc (
      .base_i   (operand_i),
      .offset_i (index_q),
      .sum_o    (idx_sum)
   );

   opres_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .mode_i      (mode_i),
      .operand_i   (operand_i),
      .idx_addr_i  (idx_sum),
      .mem_valid_i (mem_valid_i),
      .mem_data_i  (mem_data_i),
      .mem_req_o   (mem_req_o),
      .addr_o      (addr_w),
      .done_o      (done_o),
      .value_o     (value_o),
      .busy_o      (busy_o)
   );

   assign mem_addr_o = addr_w;
   assign eaddr_o    = addr_w;
endmodule

// File: rtl/opres_checker.sv
module opres_checker #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [1:0]        mode_i,
   input logic [ADDR_W-1:0] operand_i,
   input logic              mem_req_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_valid_i,
   input logic              done_o,
   input logic [DATA_W-1:0] value_o,
   input logic              busy_o
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !done_o && !mem_req_o && !busy_o);

   assert_imm_noread_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && mode_i == 2'b00
      |=> done_o && !mem_req_o && value_o == DATA_W'($past(operand_i)));

   assert_dir_first_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && mode_i == 2'b01
      |=> mem_req_o && mem_addr_o == $past(operand_i));

   assert_ind_first_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && mode_i == 2'b10
      |=> mem_req_o && mem_addr_o == $past(operand_i));

   assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);

   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !done_o |=> busy_o);
endmodule

bind opnd_resolver opres_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .mode_i      (mode_i),
   .operand_i   (operand_i),
   .mem_req_o   (mem_req_o),
   .mem_addr_o  (mem_addr_o),
   .mem_valid_i (mem_valid_i),
   .done_o      (done_o),
   .value_o     (value_o),
   .busy_o      (busy_o)
);

// File: tb/opnd_resolver_tb_top.sv
module opnd_resolver_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int NVEC = 8;

   // vector: mode[21:20] operand[19:12] index[11:4] latency[3:0]
   localparam logic [21:0] VEC [0:NVEC-1] = '{
      {2'd0, 8'd42,  8'd0,  4'd0},
      {2'd0, 8'd255, 8'd9,  4'd3},
      {2'd1, 8'd17,  8'd0,  4'd0},
      {2'd1, 8'd200, 8'd0,  4'd6},
      {2'd2, 8'd33,  8'd0,  4'd1},
      {2'd2, 8'd90,  8'd0,  4'd4},
      {2'd3, 8'd10,  8'd3,  4'd2},
      {2'd3, 8'd250, 8'd10, 4'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    mode_i = '0;
   logic [AW-1:0] operand_i = '0;
   logic          idx_load_i = 1'b0;
   logic [AW-1:0] idx_value_i = '0;
   logic          mem_req_o;
   logic [AW-1:0] mem_addr_o;
   logic          mem_valid_i = 1'b0;
   logic [DW-1:0] mem_data_i = '0;
   logic          done_o;
   logic [DW-1:0] value_o;
   logic [AW-1:0] eaddr_o;
   logic          busy_o;

   int total = 0;
   int bad = 0;
   int lat = 0;
   int lat_cnt = 0;
   int rd_cnt = 0;
   logic [AW-1:0] rd_addr [0:3];

   always #(CLK_PERIOD/2) clk = ~clk;

   opnd_resolver dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .operand_i(operand_i), .idx_load_i(idx_load_i), .idx_value_i(idx_value_i),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i),
      .mem_data_i(mem_data_i), .done_o(done_o), .value_o(value_o),
      .eaddr_o(eaddr_o), .busy_o(busy_o)
   );

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return DW'(a) * 16'd37 + 16'd11;
   endfunction

   // memory model: one-cycle valid after lat extra cycles
   always @(posedge clk) begin
      if (mem_req_o && mem_valid_i) begin
         if (rd_cnt < 4) rd_addr[rd_cnt] <= mem_addr_o;
         rd_cnt <= rd_cnt + 1;
      end
      if (mem_valid_i) begin
         mem_valid_i <= 1'b0;
      end else if (mem_req_o) begin
         if (lat_cnt >= lat) begin
            mem_valid_i <= 1'b1;
            mem_data_i  <= memf(mem_addr_o);
            lat_cnt     <= 0;
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_one(input logic [1:0] m, input logic [AW-1:0] op,
                          input bit do_load, input logic [AW-1:0] idx,
                          input int l, input logic [AW-1:0] exp_ea,
                          input int exp_rd, input string req);
      int n;
      logic [DW-1:0] exp_val;
      if (do_load) begin
         @(negedge clk); idx_load_i = 1'b1; idx_value_i = idx;
         @(negedge clk); idx_load_i = 1'b0;
      end else begin
         @(negedge clk);
      end
      lat = l; rd_cnt = 0;
      start_i = 1'b1; mode_i = m; operand_i = op;
      @(negedge clk); start_i = 1'b0;
      n = 0;
      while (!done_o && n < 100) begin
         @(negedge clk); n++;
      end
      exp_val = (m == 2'b00) ? DW'(op) : memf(exp_ea);
      chk(done_o == 1'b1, req, int'(done_o), 1);
      chk(value_o == exp_val, req, int'(value_o), int'(exp_val));
      chk(eaddr_o == exp_ea, req, int'(eaddr_o), int'(exp_ea));
      chk(rd_cnt == exp_rd, req, rd_cnt, exp_rd);
      if (m == 2'b00) chk(n == 0, "R2 latency", n, 0);
      @(negedge clk);
      chk(!done_o && !busy_o, "R7 single done", int'(done_o), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [AW-1:0] ea;
      repeat (3) @(negedge clk);
      chk(!done_o && !mem_req_o && !busy_o, "R1 reset", int'(busy_o), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         logic [1:0] m;
         logic [AW-1:0] op, ix;
         int l, nr;
         m = VEC[i][21:20]; op = VEC[i][19:12]; ix = VEC[i][11:4]; l = int'(VEC[i][3:0]);
         case (m)
            2'b00: begin ea = op; nr = 0; end
            2'b01: begin ea = op; nr = 1; end
            2'b10: begin ea = memf(op)[AW-1:0]; nr = 2; end
            default: begin ea = op + ix; nr = 1; end
         endcase
         run_one(m, op, 1'b1, ix, l, ea, nr,
                 m == 2'b00 ? "R2 immediate" : m == 2'b01 ? "R3 direct" :
                 m == 2'b10 ? "R4 indirect" : "R5 indexed");
         if (m == 2'b10) begin
            chk(rd_addr[0] == op, "R4 first addr", int'(rd_addr[0]), int'(op));
            chk(rd_addr[1] == ea, "R4 second addr", int'(rd_addr[1]), int'(ea));
         end
         if (m == 2'b11) chk(rd_addr[0] == ea, "R5 read addr", int'(rd_addr[0]), int'(ea));
      end

      // R5 wrap corner: 250 + 10 = 4
      run_one(2'b11, 8'd250, 1'b1, 8'd10, 1, 8'd4, 1, "R5 wrap");

      // R6 long latency
      run_one(2'b10, 8'd7, 1'b0, 8'd0, 12, memf(8'd7)[AW-1:0], 2, "R6 long latency");

      // R8 start while busy is ignored
      @(negedge clk);
      lat = 5; rd_cnt = 0;
      start_i = 1'b1; mode_i = 2'b01; operand_i = 8'd20;
      @(negedge clk); start_i = 1'b0;
      chk(busy_o == 1'b1, "R8 busy", int'(busy_o), 1);
      @(negedge clk);
      start_i = 1'b1; mode_i = 2'b00; operand_i = 8'd99;
      @(negedge clk); start_i = 1'b0; operand_i = 8'd0;
      for (int k = 0; k < 50 && !done_o; k++) @(negedge clk);
      chk(value_o == memf(8'd20), "R8 ignored start", int'(value_o), int'(memf(8'd20)));
      chk(eaddr_o == 8'd20, "R8 ignored start ea", int'(eaddr_o), 20);
      chk(rd_cnt == 1, "R8 reads", rd_cnt, 1);
      @(negedge clk);

      // R9 load during resolution does not disturb it
      @(negedge clk); idx_load_i = 1'b1; idx_value_i = 8'd3;
      @(negedge clk); idx_load_i = 1'b0;
      lat = 4; rd_cnt = 0;
      start_i = 1'b1; mode_i = 2'b11; operand_i = 8'd5;
      @(negedge clk); start_i = 1'b0;
      idx_load_i = 1'b1; idx_value_i = 8'd100;
      @(negedge clk); idx_load_i = 1'b0;
      for (int k = 0; k < 50 && !done_o; k++) @(negedge clk);
      chk(eaddr_o == 8'd8, "R9 in-flight load", int'(eaddr_o), 8);
      chk(value_o == memf(8'd8), "R9 in-flight value", int'(value_o), int'(memf(8'd8)));
      @(negedge clk);
      // new index now in effect
      run_one(2'b11, 8'd5, 1'b0, 8'd0, 0, 8'd105, 1, "R9 new index");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule